// File: doc/BRIEF.md
# Two-Channel Serial Controller Host Register Port

This block is the host-facing access logic of a two-channel serial controller. Each channel has just two byte-wide ports: a control port and a data port. Most internal registers sit behind a per-channel index pointer. Register 0 is reached directly. For any other register, the host writes its index to the control port, and the next control access on that channel reads or writes it. The pointer then falls back to 0 by itself.

A register-0 write does three things at once. Bits 2:0 load the pointer. Command bits 5:3 either select the upper half of the index space or fire one of six single-cycle command strobes. Bits 7:6 fire one of three checksum and end-of-message strobes.

Each channel keeps seventeen write registers: indices 0 to 15 plus a shadow register at index 7. The shadow register is chosen in place of index 7 while bit 0 of register 15 is set. Bit 6 of the shadow register lets control reads return the stored write registers. Data-port writes go straight to the transmit buffer and data-port reads go straight to the receive buffer, with no pointer involved. The whole register file is presented in parallel on `cfg_o` for the serializer and clocking logic.

Top module: `sio_regport`

## Requirements
- R1: After reset every pointer is 0, every write register slot on `cfg_o` is 0x00, and no command, checksum or transmit strobe is active.
- R2: A control write with the pointer at 0 stores the byte in slot 0 and loads the pointer from bits 2:0. The next control write on that channel lands in that slot (indices 1 to 7). After that access the pointer is back at 0.
- R3: A register-0 write whose bits 5:3 equal 3'b001 (value 0x08 in that field) adds 8 to the pointer, so the next control write lands in slot 8 plus bits 2:0 (slots 9 to 15).
- R4: Bits 5:3 of a register-0 write, for codes 2 to 7, raise `cmd_pulse_o[ch]` bit (code-2) for exactly the one cycle after the access. Bit 0 resets external status, 1 sends abort, 2 re-arms receive first-character, 3 clears transmit pending, 4 resets errors, 5 clears the highest in-service level. Codes 0 and 1 raise none.
- R5: Bits 7:6 of a register-0 write, for values 1 to 3, raise `crc_pulse_o[ch]` bit (value-1) for one cycle after the access. Bit 0 resets the receive checksum, 1 resets the transmit checksum, 2 resets the end-of-message latch.
- R6: While bit 0 of slot 15 is 1, writes to index 7 go to slot 16 (the shadow) and leave slot 7 unchanged. While it is 0, they go to slot 7.
- R7: A control read of an index other than 0, 1 and 8 returns the stored slot (the shadow slot for index 7 when R6 selects it) while bit 6 of slot 16 is 1, and 0x00 otherwise.
- R8: A control read with the pointer at 0 returns `st0_i[ch]` without any prior pointer write. A read at index 1 returns `st1_i[ch]`. Any control read at a non-zero index returns the pointer to 0.
- R9: A data-port write raises `tx_wr_o[ch]` with `tx_data_o` equal to the byte in the cycle after the access, and changes neither the register slots nor the pointer. A data-port read returns `rx_data_i[ch]` and raises `rx_rd_o[ch]` in the same cycle.
- R10: The two channels keep separate pointers and register files: an access on one channel changes no slot and no pointer of the other.
- R11: A control write at index 8 acts as a transmit-buffer write as in R9 and leaves slot 8 at 0x00. A control read at index 8 returns the receive buffer and raises `rx_rd_o[ch]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en | input | 1 | Host access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 1 | 0 = control port, 1 = data port |
| acc_chan | input | CH_W | Channel addressed |
| acc_wdata | input | DATA_W | Write byte |
| acc_rdata | output | DATA_W | Read byte, valid in the access cycle |
| st0_i | input | NCH x DATA_W | Status byte returned at index 0, per channel |
| st1_i | input | NCH x DATA_W | Status byte returned at index 1, per channel |
| rx_data_i | input | NCH x DATA_W | Receive buffer head, per channel |
| rx_rd_o | output | NCH | Receive buffer read strobe, per channel |
| tx_wr_o | output | NCH | Transmit buffer load strobe, per channel |
| tx_data_o | output | DATA_W | Byte that goes with `tx_wr_o` |
| cmd_pulse_o | output | NCH x 6 | Register-0 command strobes |
| crc_pulse_o | output | NCH x 3 | Checksum and end-of-message strobes |
| cfg_o | output | NCH x NSLOT x DATA_W | All write register slots, per channel |

## Verification
The command decoder is swept across all eight command codes combined with all four checksum codes on both channels. This separates a missing strobe, a strobe on the wrong bit, a strobe on the wrong channel, and a strobe held for longer than one cycle. Every index from 1 to 15 except 8 is written through the pointer with a value that depends on both index and channel. That pattern exposes a pointer that does not clear, a lost upper-half offset, and writes leaking between channels. The shadow-register and readback cases toggle the register-15 select and the readback enable in turn, so each read can only match when the index-7 steering is right. Data-port and index-8 accesses are interleaved with a pending pointer to show that the buffer path leaves pointer state alone.

// File: rtl/sio_regport_pkg.sv
package sio_regport_pkg;

   // Command field (bits 5:3) of a register-0 write
   typedef enum logic [2:0] {
      CMD_NONE     = 3'd0,
      CMD_UPPER    = 3'd1,
      CMD_EXT_CLR  = 3'd2,
      CMD_ABORT    = 3'd3,
      CMD_RX_REARM = 3'd4,
      CMD_TX_CLR   = 3'd5,
      CMD_ERR_CLR  = 3'd6,
      CMD_SVC_CLR  = 3'd7
   } ctl_cmd_e;

   localparam int unsigned N_CMD_PULSE = 6;
   localparam int unsigned N_CRC_PULSE = 3;
   localparam int unsigned IDX_W       = 4;
   localparam int unsigned BUF_IDX     = 8;
   localparam int unsigned SHADOW_IDX  = 7;

endpackage

// File: rtl/sio_ptr_unit.sv
module sio_ptr_unit
   import sio_regport_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_acc,
   input  logic              ctl_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [IDX_W-1:0]  ptr_o
);

   logic [IDX_W-1:0] ptr_q, ptr_d;
   ctl_cmd_e         cmd;

   assign cmd = ctl_cmd_e'(wdata[5:3]);

   always_comb begin
      ptr_d = ptr_q;
      if (ctl_acc) begin
         if (ptr_q != '0) begin
            ptr_d = '0;
         end else if (ctl_wr) begin
            ptr_d = {(cmd == CMD_UPPER), wdata[2:0]};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q <= '0;
      else        ptr_q <= ptr_d;
   end

   assign ptr_o = ptr_q;

endmodule

// File: rtl/sio_cmd_decode.sv
module sio_cmd_decode
   import sio_regport_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr0_stb,
   input  logic [DATA_W-1:0]      wdata,
   output logic [N_CMD_PULSE-1:0] cmd_o,
   output logic [N_CRC_PULSE-1:0] crc_o
);

   logic [N_CMD_PULSE-1:0] cmd_d;
   logic [N_CRC_PULSE-1:0] crc_d;

   for (genvar k = 0; k < N_CMD_PULSE; k++) begin : g_cmd
      assign cmd_d[k] = wr0_stb && (wdata[5:3] == 3'(k + 2));
   end

   for (genvar k = 0; k < N_CRC_PULSE; k++) begin : g_crc
      assign crc_d[k] = wr0_stb && (wdata[7:6] == 2'(k + 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_o <= '0;
         crc_o <= '0;
      end else begin
         cmd_o <= cmd_d;
         crc_o <= crc_d;
      end
   end

endmodule

// File: rtl/sio_reg_bank.sv
module sio_reg_bank
   import sio_regport_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter bit          ALT_EN   = 1'b1,
   parameter int unsigned ALT_BIT  = 0,
   parameter int unsigned RDBK_BIT = 6,
   localparam int unsigned NSLOT   = ALT_EN ? 17 : 16,
   localparam int unsigned SLOT_W  = $clog2(NSLOT)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [IDX_W-1:0]              idx,
   input  logic [DATA_W-1:0]             wdata,
   output logic [NSLOT-1:0][DATA_W-1:0]  regs_o,
   output logic [DATA_W-1:0]             rd_word_o,
   output logic                          rdbk_en_o
);

   logic [NSLOT-1:0][DATA_W-1:0] mem_q;
   logic [SLOT_W-1:0]            slot;

   if (ALT_EN) begin : g_shadow
      logic alt_on;
      assign alt_on    = mem_q[15][ALT_BIT];
      assign slot      = (alt_on && idx == IDX_W'(SHADOW_IDX)) ? SLOT_W'(16) : SLOT_W'(idx);
      assign rdbk_en_o = mem_q[16][RDBK_BIT];
   end else begin : g_plain
      assign slot      = SLOT_W'(idx);
      assign rdbk_en_o = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem_q       <= '0;
      else if (we) mem_q[slot] <= wdata;
   end

   assign regs_o    = mem_q;
   assign rd_word_o = mem_q[slot];

endmodule

// File: rtl/sio_regport.sv
module sio_regport
   import sio_regport_pkg::*;
#(
   parameter int unsigned NCH      = 2,
   parameter int unsigned DATA_W   = 8,
   parameter bit          ALT_EN   = 1'b1,
   parameter int unsigned ALT_BIT  = 0,
   parameter int unsigned RDBK_BIT = 6,
   localparam int unsigned CH_W    = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int unsigned NSLOT   = ALT_EN ? 17 : 16
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   acc_en,
   input  logic                                   acc_wr,
   input  logic                                   acc_sel,
   input  logic [CH_W-1:0]                        acc_chan,
   input  logic [DATA_W-1:0]                      acc_wdata,
   output logic [DATA_W-1:0]                      acc_rdata,
   input  logic [NCH-1:0][DATA_W-1:0]             st0_i,
   input  logic [NCH-1:0][DATA_W-1:0]             st1_i,
   input  logic [NCH-1:0][DATA_W-1:0]             rx_data_i,
   output logic [NCH-1:0]                         rx_rd_o,
   output logic [NCH-1:0]                         tx_wr_o,
   output logic [DATA_W-1:0]                      tx_data_o,
   output logic [NCH-1:0][N_CMD_PULSE-1:0]        cmd_pulse_o,
   output logic [NCH-1:0][N_CRC_PULSE-1:0]        crc_pulse_o,
   output logic [NCH-1:0][NSLOT-1:0][DATA_W-1:0]  cfg_o
);

   if (DATA_W != 8) begin : g_bad_width
      $error("sio_regport: DATA_W must be 8");
   end
   if (NCH < 1 || NCH > 8) begin : g_bad_nch
      $error("sio_regport: NCH out of range");
   end
   if (ALT_BIT >= DATA_W || RDBK_BIT >= DATA_W) begin : g_bad_bits
      $error("sio_regport: select bits out of range");
   end

   logic [NCH-1:0][DATA_W-1:0] rd_ch;
   logic [NCH-1:0]             tx_stb;
   logic [NCH-1:0]             tx_wr_q;
   logic [DATA_W-1:0]          tx_data_q;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic              hit, ctl, at_buf, at_zero;
      logic [IDX_W-1:0]  ptr;
      logic [DATA_W-1:0] stored;
      logic              rdbk_en;

      assign hit     = acc_en && (acc_chan == CH_W'(c));
      assign ctl     = hit && !acc_sel;
      assign at_buf  = (ptr == IDX_W'(BUF_IDX));
      assign at_zero = (ptr == '0);

      sio_ptr_unit #(.DATA_W(DATA_W)) u_ptr (
         .clk     (clk),
         .rst_n   (rst_n),
         .ctl_acc (ctl),
         .ctl_wr  (acc_wr),
         .wdata   (acc_wdata),
         .ptr_o   (ptr)
      );

      sio_cmd_decode #(.DATA_W(DATA_W)) u_cmd (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr0_stb (ctl && acc_wr && at_zero),
         .wdata   (acc_wdata),
         .cmd_o   (cmd_pulse_o[c]),
         .crc_o   (crc_pulse_o[c])
      );

      sio_reg_bank #(
         .DATA_W   (DATA_W),
         .ALT_EN   (ALT_EN),
         .ALT_BIT  (ALT_BIT),
         .RDBK_BIT (RDBK_BIT)
      ) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .we        (ctl && acc_wr && !at_buf),
         .idx       (ptr),
         .wdata     (acc_wdata),
         .regs_o    (cfg_o[c]),
         .rd_word_o (stored),
         .rdbk_en_o (rdbk_en)
      );

      assign tx_stb[c]  = hit && acc_wr && (acc_sel || at_buf);
      assign rx_rd_o[c] = hit && !acc_wr && (acc_sel || at_buf);

      always_comb begin
         if (acc_sel || at_buf)          rd_ch[c] = rx_data_i[c];
         else if (at_zero)               rd_ch[c] = st0_i[c];
         else if (ptr == IDX_W'(1))      rd_ch[c] = st1_i[c];
         else if (rdbk_en)               rd_ch[c] = stored;
         else                            rd_ch[c] = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_wr_q   <= '0;
         tx_data_q <= '0;
      end else begin
         tx_wr_q <= tx_stb;
         if (|tx_stb) tx_data_q <= acc_wdata;
      end
   end

   assign tx_wr_o   = tx_wr_q;
   assign tx_data_o = tx_data_q;
   assign acc_rdata = (acc_en && !acc_wr) ? rd_ch[acc_chan] : '0;

endmodule

// File: rtl/sio_regport_chk.sv
module sio_regport_chk
   import sio_regport_pkg::*;
#(
   parameter int unsigned NCH    = 2,
   parameter int unsigned DATA_W = 8,
   parameter bit          ALT_EN = 1'b1,
   localparam int unsigned CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int unsigned NSLOT = ALT_EN ? 17 : 16
) (
   input logic                                  clk,
   input logic                                  rst_n,
   input logic                                  acc_en,
   input logic                                  acc_wr,
   input logic                                  acc_sel,
   input logic [CH_W-1:0]                       acc_chan,
   input logic [NCH-1:0]                        rx_rd_o,
   input logic [NCH-1:0]                        tx_wr_o,
   input logic [NCH-1:0][N_CMD_PULSE-1:0]       cmd_pulse_o,
   input logic [NCH-1:0][N_CRC_PULSE-1:0]       crc_pulse_o,
   input logic [NCH-1:0][NSLOT-1:0][DATA_W-1:0] cfg_o
);

   a_r9_single_tx_load: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tx_wr_o));

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      a_r4_cmd_after_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
         (|cmd_pulse_o[c]) |-> $past(acc_en && acc_wr && !acc_sel && acc_chan == CH_W'(c)));

      a_r5_crc_after_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
         (|crc_pulse_o[c]) |-> $past(acc_en && acc_wr && !acc_sel && acc_chan == CH_W'(c)));

      a_r9_tx_after_write: assert property (@(posedge clk) disable iff (!rst_n)
         tx_wr_o[c] |-> $past(acc_en && acc_wr && acc_chan == CH_W'(c)));

      a_r9_rx_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
         rx_rd_o[c] |-> (acc_en && !acc_wr && acc_chan == CH_W'(c)));

      a_r10_cfg_only_own_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(cfg_o[c]) |-> $past(acc_en && acc_wr && !acc_sel && acc_chan == CH_W'(c)));
   end

endmodule

bind sio_regport sio_regport_chk #(
   .NCH    (NCH),
   .DATA_W (DATA_W),
   .ALT_EN (ALT_EN)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .acc_en      (acc_en),
   .acc_wr      (acc_wr),
   .acc_sel     (acc_sel),
   .acc_chan    (acc_chan),
   .rx_rd_o     (rx_rd_o),
   .tx_wr_o     (tx_wr_o),
   .cmd_pulse_o (cmd_pulse_o),
   .crc_pulse_o (crc_pulse_o),
   .cfg_o       (cfg_o)
);

// File: tb/sio_regport_tb_top.sv
module sio_regport_tb_top;

   localparam int NCH = 2;
   localparam int NS  = 17;

   logic                        clk = 1'b0;
   logic                        rst_n = 1'b0;
   logic                        acc_en = 1'b0, acc_wr = 1'b0, acc_sel = 1'b0;
   logic [0:0]                  acc_chan = '0;
   logic [7:0]                  acc_wdata = '0;
   logic [7:0]                  acc_rdata;
   logic [NCH-1:0][7:0]         st0, st1, rxd;
   logic [NCH-1:0]              rx_rd, tx_wr;
   logic [7:0]                  tx_data;
   logic [NCH-1:0][5:0]         cmd_p;
   logic [NCH-1:0][2:0]         crc_p;
   logic [NCH-1:0][NS-1:0][7:0] cfg;

   int         n_tests = 0, n_fail = 0;
   bit         done = 1'b0;
   logic [7:0] mdl [NCH][NS];
   logic [7:0] rv;
   logic       rx_seen;

   always #4 clk = ~clk;

   sio_regport dut_i (
      .clk (clk), .rst_n (rst_n), .acc_en (acc_en), .acc_wr (acc_wr),
      .acc_sel (acc_sel), .acc_chan (acc_chan), .acc_wdata (acc_wdata),
      .acc_rdata (acc_rdata), .st0_i (st0), .st1_i (st1), .rx_data_i (rxd),
      .rx_rd_o (rx_rd), .tx_wr_o (tx_wr), .tx_data_o (tx_data),
      .cmd_pulse_o (cmd_p), .crc_pulse_o (crc_p), .cfg_o (cfg)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic access(input int ch, input logic wr, input logic sel, input logic [7:0] v);
      @(negedge clk);
      acc_en = 1'b1; acc_wr = wr; acc_sel = sel; acc_chan = 1'(ch); acc_wdata = v;
      #1;
      rv = acc_rdata;
      rx_seen = rx_rd[ch];
      @(negedge clk);
      acc_en = 1'b0;
   endtask

   task automatic ctl_wr(input int ch, input logic [7:0] v);
      access(ch, 1'b1, 1'b0, v);
   endtask

   task automatic ctl_rd(input int ch);
      access(ch, 1'b0, 1'b0, 8'h00);
   endtask

   task automatic wr_reg(input int ch, input int idx, input logic [7:0] v);
      logic [7:0] pb;
      int slot;
      pb = (idx >= 8) ? (8'h08 | 8'(idx % 8)) : 8'(idx);
      ctl_wr(ch, pb);
      mdl[ch][0] = pb;
      slot = (idx == 7 && mdl[ch][15][0]) ? 16 : idx;
      ctl_wr(ch, v);
      mdl[ch][slot] = v;
   endtask

   task automatic chk_slot(input string req, input int ch, input int slot);
      chk(req, 32'(cfg[ch][slot]), 32'(mdl[ch][slot]));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      st0 = {8'h3C, 8'hA5};
      st1 = {8'hC3, 8'h5A};
      rxd = {8'h1E, 8'h91};
      for (int c = 0; c < NCH; c++)
         for (int s = 0; s < NS; s++) mdl[c][s] = 8'h00;

      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 cfg zero", 32'(|cfg), 0);
      chk("R1 no strobes", 32'({cmd_p, crc_p, tx_wr}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R8 status read without pointer write
      ctl_rd(0); chk("R8 st0 ch0", 32'(rv), 32'hA5);
      ctl_rd(1); chk("R8 st0 ch1", 32'(rv), 32'h3C);

      // R2/R3 sweep of every pointer-reached index on both channels
      for (int ch = 0; ch < NCH; ch++) begin
         for (int idx = 1; idx < 16; idx++) begin
            if (idx == 8) continue;
            wr_reg(ch, idx, 8'((idx * 37 + ch * 11 + 1) & 8'hFE));
            chk_slot(idx < 8 ? "R2 slot write" : "R3 upper slot write", ch, idx);
            chk_slot(idx < 8 ? "R2 pointer byte" : "R3 pointer byte", ch, 0);
            ctl_rd(ch);
            chk("R2 pointer back to 0", 32'(rv), 32'(st0[ch]));
         end
      end
      // R10 channel 0 untouched by channel 1 sweep
      for (int idx = 0; idx < NS; idx++) chk_slot("R10 ch0 intact", 0, idx);

      // R10 separate pointers
      ctl_wr(0, 8'h03); mdl[0][0] = 8'h03;
      ctl_rd(1); chk("R10 ch1 pointer at 0", 32'(rv), 32'h3C);
      ctl_wr(0, 8'h77); mdl[0][3] = 8'h77;
      chk_slot("R10 ch0 slot3", 0, 3);
      chk_slot("R10 ch1 slot3", 1, 3);

      // R4/R5 command and checksum sweep
      for (int ch = 0; ch < NCH; ch++) begin
         for (int cr = 0; cr < 4; cr++) begin
            for (int cd = 0; cd < 8; cd++) begin
               logic [7:0] v;
               v = {2'(cr), 3'(cd), 3'b000};
               ctl_wr(ch, v); mdl[ch][0] = v;
               chk("R4 cmd strobe", 32'(cmd_p[ch]), (cd >= 2) ? 32'(1 << (cd - 2)) : 0);
               chk("R5 crc strobe", 32'(crc_p[ch]), (cr >= 1) ? 32'(1 << (cr - 1)) : 0);
               chk("R4 other channel quiet", 32'({cmd_p[1-ch], crc_p[1-ch]}), 0);
               @(negedge clk);
               chk("R4 R5 one cycle", 32'({cmd_p[ch], crc_p[ch]}), 0);
               chk_slot("R2 wr0 stored", ch, 0);
               if (cd == 1) begin
                  ctl_rd(ch);
                  chk("R11 index 8 read data", 32'(rv), 32'(rxd[ch]));
                  chk("R11 index 8 read strobe", 32'(rx_seen), 1);
               end
            end
         end
      end

      // R6 shadow steering at index 7
      wr_reg(0, 15, 8'h01);
      wr_reg(0, 7, 8'h5E);
      chk_slot("R6 shadow written", 0, 16);
      chk_slot("R6 slot7 kept", 0, 7);
      wr_reg(0, 15, 8'h00);
      wr_reg(0, 7, 8'h6F);
      chk_slot("R6 slot7 written", 0, 7);
      chk_slot("R6 shadow kept", 0, 16);

      // R7 readback enabled (shadow bit6 set)
      ctl_wr(0, 8'h03); ctl_rd(0);
      chk("R7 readback slot3", 32'(rv), 32'(mdl[0][3]));
      ctl_wr(0, 8'h0C); ctl_rd(0);
      chk("R7 readback slot12", 32'(rv), 32'(mdl[0][12]));
      ctl_wr(0, 8'h07); ctl_rd(0);
      chk("R7 readback slot7", 32'(rv), 32'h6F);
      wr_reg(0, 15, 8'h01);
      ctl_wr(0, 8'h07); ctl_rd(0);
      chk("R7 readback shadow", 32'(rv), 32'h5E);
      ctl_wr(0, 8'h01); ctl_rd(0);
      chk("R8 index 1", 32'(rv), 32'h5A);
      wr_reg(0, 7, 8'h00);
      chk_slot("R6 shadow cleared", 0, 16);
      ctl_wr(0, 8'h03); ctl_rd(0);
      chk("R7 readback off slot3", 32'(rv), 0);
      ctl_wr(1, 8'h04); ctl_rd(1);
      chk("R7 ch1 readback off", 32'(rv), 0);
      ctl_rd(0);
      chk("R8 pointer cleared by read", 32'(rv), 32'hA5);

      // R9 data port with a pending pointer
      ctl_wr(1, 8'h05); mdl[1][0] = 8'h05;
      access(1, 1'b1, 1'b1, 8'hD2);
      chk("R9 tx strobe", 32'(tx_wr), 32'h2);
      chk("R9 tx data", 32'(tx_data), 32'hD2);
      @(negedge clk);
      chk("R9 tx strobe one cycle", 32'(tx_wr), 0);
      for (int s = 0; s < NS; s++) chk_slot("R9 slots unchanged", 1, s);
      ctl_wr(1, 8'hB4); mdl[1][5] = 8'hB4;
      chk_slot("R9 pointer kept", 1, 5);
      access(0, 1'b0, 1'b1, 8'h00);
      chk("R9 rx data", 32'(rv), 32'h91);
      chk("R9 rx strobe", 32'(rx_seen), 1);

      // R11 control write at index 8
      ctl_wr(0, 8'h08); mdl[0][0] = 8'h08;
      ctl_wr(0, 8'h44);
      chk("R11 tx strobe", 32'(tx_wr), 32'h1);
      chk("R11 tx data", 32'(tx_data), 32'h44);
      chk_slot("R11 slot8 zero", 0, 8);
      ctl_rd(0);
      chk("R11 pointer back to 0", 32'(rv), 32'hA5);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule